// File: doc/BRIEF.md
# PTP Time-of-Day Counter with Fractional Step

This block keeps precision-time-protocol wall time as a seconds count above a nanoseconds count. On every clock it adds a small nanosecond step to the time. The step follows a fixed pattern. A default step is used for a programmable number of cycles, and then one alternative step is used. The pattern repeats, so the average step per cycle can be a fraction of a nanosecond. This lets a clock whose period is not a whole number of nanoseconds still track real time. For example, a 10.2 MHz clock uses fifty 98 ns steps and then one 100 ns step, which covers 5000 ns in 51 cycles.

Software reaches the block through a small word-wide register port. It can load an absolute time, apply a signed nanosecond correction and program the step pattern. It can also read the time as two coherent halves. The live time is also driven on output ports for local consumers. A one-cycle interrupt pulse marks every carry into the seconds count.

Top module: `ptp_tod_counter`

## Requirements
- R1: While reset is held and just after its release, the time is zero, the seconds pulse is low, and the step word reads back as zero.
- R2: When bits [23:16] of the step word are zero, every cycle adds bits [7:0] of the word to the nanoseconds.
- R3: When bits [23:16] hold N > 0, the time advances by N cycles of bits [7:0] followed by one cycle of bits [15:8], and this pattern repeats. Word 0x00326462 advances 5000 ns in every 51 cycles, and word 0x00F82814 advances 5000 ns in every 249 cycles.
- R4: When the nanoseconds sum reaches NS_PER_SEC, the excess stays in the nanoseconds field, the seconds count rises by one, and 0xFFFFFFFF rolls over to 0. The nanoseconds field never holds NS_PER_SEC or more.
- R5: `sec_pulse` is high for exactly the one cycle in which the seconds count has just risen by a carry, from counting or from a correction. A software load never raises it.
- R6: Register 1 holds a pending seconds value. A write of V to register 0 loads that pending value and V[29:0] as the new time at the next edge, with no step added in that cycle. If V[29:0] is NS_PER_SEC or more, the write is ignored and counting goes on.
- R7: A write to register 3 applies a correction in the same cycle as the normal step. Bit 31 of the data selects subtraction when it is 1, and bits [29:0] give the magnitude. A borrow below zero takes one second away. A magnitude of NS_PER_SEC − 2^8 or more is ignored.
- R8: A write to register 2 stores the step word from bits [23:0]. The cycle of the write still uses the old word. The new word takes effect from the next cycle, with its pattern restarted at the first default step.
- R9: A read of register 0 returns the current nanoseconds and captures the current seconds. Reads of register 1 return that captured value until the next read of register 0.
- R10: A read of register 2 returns the stored step word in bits [23:0] and zero above. Register 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time base clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (captures seconds on register 0) |
| bus_addr | input | 2 | Register select: 0 ns/load, 1 seconds, 2 step word, 3 correction |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| tod_sec | output | 32 | Live seconds |
| tod_ns | output | 30 | Live nanoseconds |
| sec_pulse | output | 1 | One-cycle pulse on each seconds carry |

## Verification
A wrong step-pattern counter shows up as a wrong time within one pattern period. The bench catches it in two ways. It compares the live time to an arithmetic model on every cycle, and it measures the time advanced over a whole period, such as 5000 ns over 51 cycles. A wrong wrap or borrow shows at the ports on the first edge that crosses a second, both as a wrong time and as a wrong `sec_pulse`. A stale or wrong capture register shows only when register 1 is read, so the bench reads it after the live seconds have moved on.

// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;
   // register select codes; the load path depends on these positions
   typedef enum logic [1:0] {
      SEL_NS   = 2'd0,
      SEL_SEC  = 2'd1,
      SEL_INCR = 2'd2,
      SEL_ADJ  = 2'd3
   } tod_sel_e;
endpackage

// File: rtl/ptp_tod_regif.sv
module ptp_tod_regif
   import ptp_tod_pkg::*;
#(
   parameter int SEC_W  = 32,
   parameter int NS_W   = 30,
   parameter int STEP_W = 8,
   parameter int DW     = 32
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                bus_wr,
   input  logic                bus_rd,
   input  logic [1:0]          bus_addr,
   input  logic [DW-1:0]       bus_wdata,
   output logic [DW-1:0]       bus_rdata,
   input  logic [SEC_W-1:0]    cur_sec,
   input  logic [NS_W-1:0]     cur_ns,
   output logic [3*STEP_W-1:0] incr_word,
   output logic                incr_wr,
   output logic                load_en,
   output logic [SEC_W-1:0]    load_sec,
   output logic [NS_W-1:0]     load_ns,
   output logic                adj_en,
   output logic                adj_neg,
   output logic [NS_W-1:0]     adj_mag
);
   localparam int INCR_W = 3 * STEP_W;

   if (DW < SEC_W)  begin : g_chk_sec  $error("DW narrower than seconds"); end
   if (DW <= NS_W)  begin : g_chk_ns   $error("DW leaves no sign bit");   end
   if (DW < INCR_W) begin : g_chk_incr $error("DW narrower than step word"); end

   tod_sel_e         sel;
   logic [SEC_W-1:0] stage_q;
   logic [SEC_W-1:0] shadow_q;
   logic [INCR_W-1:0] incr_q;
   logic             unused_wdata;

   assign sel          = tod_sel_e'(bus_addr);
   assign unused_wdata = ^bus_wdata;

   assign incr_wr   = bus_wr && (sel == SEL_INCR);
   assign load_en   = bus_wr && (sel == SEL_NS);
   assign adj_en    = bus_wr && (sel == SEL_ADJ);
   assign load_sec  = stage_q;
   assign load_ns   = bus_wdata[NS_W-1:0];
   assign adj_mag   = bus_wdata[NS_W-1:0];
   assign adj_neg   = bus_wdata[DW-1];
   assign incr_word = incr_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         stage_q  <= '0;
         shadow_q <= '0;
         incr_q   <= '0;
      end else begin
         if (bus_wr && sel == SEL_SEC) stage_q <= bus_wdata[SEC_W-1:0];
         if (incr_wr)                  incr_q  <= bus_wdata[INCR_W-1:0];
         if (bus_rd && sel == SEL_NS)  shadow_q <= cur_sec;
      end
   end

   always_comb begin
      case (sel)
         SEL_NS:   bus_rdata = DW'(cur_ns);
         SEL_SEC:  bus_rdata = DW'(shadow_q);
         SEL_INCR: bus_rdata = DW'(incr_q);
         default:  bus_rdata = '0;
      endcase
   end

   // R9: the capture holds the seconds seen in the cycle of the ns read
   p_capture_r9: assert property (@(posedge clk) disable iff (rst)
      (bus_rd && sel == SEL_NS) |=> (shadow_q == $past(cur_sec)));

   // R8: the step word only changes through a step-word write
   p_incr_hold_r8: assert property (@(posedge clk) disable iff (rst)
      !incr_wr |=> $stable(incr_q));
endmodule

// File: rtl/ptp_tod_stepgen.sv
module ptp_tod_stepgen #(
   parameter int STEP_W = 8,
   parameter bit ALT_EN = 1'b1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [3*STEP_W-1:0] incr_word,
   input  logic                incr_wr,
   output logic [STEP_W-1:0]   step,
   output logic                alt_sel
);
   if (STEP_W < 1) begin : g_chk_w $error("STEP_W must be positive"); end

   if (ALT_EN) begin : g_alt
      logic [STEP_W-1:0] cnt_q;
      logic [STEP_W-1:0] run_len;

      assign run_len = incr_word[3*STEP_W-1:2*STEP_W];
      assign alt_sel = (run_len != '0) && (cnt_q == run_len);
      assign step    = alt_sel ? incr_word[2*STEP_W-1:STEP_W]
                               : incr_word[STEP_W-1:0];

      always_ff @(posedge clk) begin
         if (rst)                              cnt_q <= '0;
         else if (incr_wr)                     cnt_q <= '0;
         else if (run_len == '0 || alt_sel)    cnt_q <= '0;
         else                                  cnt_q <= cnt_q + 1'b1;
      end

      // R3: never two alternative steps back to back
      p_alt_single_r3: assert property (@(posedge clk) disable iff (rst)
         alt_sel |=> !alt_sel);

      // R3: the run counter never passes the programmed run length
      p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
         (run_len != '0) |-> (cnt_q <= run_len));

      // R8: a new word starts with a default step
      p_restart_r8: assert property (@(posedge clk) disable iff (rst)
         incr_wr |=> !alt_sel);
   end else begin : g_plain
      logic unused_plain;
      assign unused_plain = ^{clk, rst, incr_wr, incr_word[3*STEP_W-1:STEP_W]};
      assign alt_sel      = 1'b0;
      assign step         = incr_word[STEP_W-1:0];
   end
endmodule

// File: rtl/ptp_tod_core.sv
module ptp_tod_core #(
   parameter int          SEC_W      = 32,
   parameter int          NS_W       = 30,
   parameter int          STEP_W     = 8,
   parameter int unsigned NS_PER_SEC = 1000000000
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [STEP_W-1:0] step,
   input  logic              load_en,
   input  logic [SEC_W-1:0]  load_sec,
   input  logic [NS_W-1:0]   load_ns,
   input  logic              adj_en,
   input  logic              adj_neg,
   input  logic [NS_W-1:0]   adj_mag,
   output logic [SEC_W-1:0]  sec,
   output logic [NS_W-1:0]   ns,
   output logic              sec_tick
);
   localparam int SW = NS_W + 2;
   localparam logic signed [SW-1:0] NPS_S   = $signed(SW'(NS_PER_SEC));
   localparam logic [NS_W-1:0]      NPS_U   = NS_W'(NS_PER_SEC);
   localparam logic [NS_W-1:0]      ADJ_LIM = NS_W'(NS_PER_SEC - (2 ** STEP_W));

   if (NS_W > 30)  begin : g_chk_nsw $error("NS_W above 30 not supported"); end
   if (NS_PER_SEC >= (2 ** NS_W)) begin : g_chk_nps $error("NS_PER_SEC too wide"); end
   if (NS_PER_SEC <= 2 * (2 ** STEP_W)) begin : g_chk_step $error("step too large for NS_PER_SEC"); end
   if (SW <= STEP_W) begin : g_chk_sw $error("STEP_W wider than ns sum"); end

   logic                 load_ok, adj_ok, carry_up, carry_dn;
   logic signed [SW-1:0] mag_s, adj_s, sum_s;
   logic [NS_W-1:0]      ns_nx;
   logic [SEC_W-1:0]     sec_nx;

   always_comb begin
      load_ok = load_en && (load_ns < NPS_U);
      adj_ok  = adj_en && (adj_mag < ADJ_LIM);
      mag_s   = $signed({2'b00, adj_mag});
      adj_s   = '0;
      if (adj_ok) adj_s = adj_neg ? -mag_s : mag_s;
      sum_s    = $signed({2'b00, ns}) + $signed({{(SW-STEP_W){1'b0}}, step}) + adj_s;
      carry_up = (sum_s >= NPS_S);
      carry_dn = (sum_s < 0);
      if (load_ok) begin
         ns_nx  = load_ns;
         sec_nx = load_sec;
      end else if (carry_up) begin
         ns_nx  = NS_W'(sum_s - NPS_S);
         sec_nx = sec + 1'b1;
      end else if (carry_dn) begin
         ns_nx  = NS_W'(sum_s + NPS_S);
         sec_nx = sec - 1'b1;
      end else begin
         ns_nx  = NS_W'(sum_s);
         sec_nx = sec;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         sec      <= '0;
         ns       <= '0;
         sec_tick <= 1'b0;
      end else begin
         sec      <= sec_nx;
         ns       <= ns_nx;
         sec_tick <= !load_ok && carry_up;
      end
   end

   // R4: ns stays below one second
   p_ns_range_r4: assert property (@(posedge clk) disable iff (rst)
      ns < NPS_U);

   // R4: without a load the seconds move by at most one
   p_sec_move_r4: assert property (@(posedge clk) disable iff (rst)
      $past(!load_ok) |-> (sec == $past(sec) || sec == SEC_W'($past(sec) + 1'b1)
                           || sec == SEC_W'($past(sec) - 1'b1)));

   // R5: a pulse always comes with a one-second rise
   p_tick_sec_r5: assert property (@(posedge clk) disable iff (rst)
      sec_tick |-> (sec == SEC_W'($past(sec) + 1'b1)));

   // R5: a load never pulses
   p_tick_load_r5: assert property (@(posedge clk) disable iff (rst)
      $past(load_ok) |-> !sec_tick);
endmodule

// File: rtl/ptp_tod_counter.sv
module ptp_tod_counter #(
   parameter int          SEC_W      = 32,
   parameter int          NS_W       = 30,
   parameter int          STEP_W     = 8,
   parameter int          DW         = 32,
   parameter int unsigned NS_PER_SEC = 1000000000,
   parameter bit          ALT_EN     = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             bus_wr,
   input  logic             bus_rd,
   input  logic [1:0]       bus_addr,
   input  logic [DW-1:0]    bus_wdata,
   output logic [DW-1:0]    bus_rdata,
   output logic [SEC_W-1:0] tod_sec,
   output logic [NS_W-1:0]  tod_ns,
   output logic             sec_pulse
);
   logic [3*STEP_W-1:0] incr_word;
   logic                incr_wr, load_en, adj_en, adj_neg, alt_sel;
   logic [SEC_W-1:0]    load_sec;
   logic [NS_W-1:0]     load_ns, adj_mag;
   logic [STEP_W-1:0]   step;
   logic                unused_alt;

   assign unused_alt = alt_sel;

   ptp_tod_regif #(.SEC_W(SEC_W), .NS_W(NS_W), .STEP_W(STEP_W), .DW(DW)) u_regif (
      .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cur_sec(tod_sec), .cur_ns(tod_ns),
      .incr_word(incr_word), .incr_wr(incr_wr), .load_en(load_en), .load_sec(load_sec),
      .load_ns(load_ns), .adj_en(adj_en), .adj_neg(adj_neg), .adj_mag(adj_mag)
   );

   ptp_tod_stepgen #(.STEP_W(STEP_W), .ALT_EN(ALT_EN)) u_stepgen (
      .clk(clk), .rst(rst), .incr_word(incr_word), .incr_wr(incr_wr),
      .step(step), .alt_sel(alt_sel)
   );

   ptp_tod_core #(.SEC_W(SEC_W), .NS_W(NS_W), .STEP_W(STEP_W), .NS_PER_SEC(NS_PER_SEC)) u_core (
      .clk(clk), .rst(rst), .step(step), .load_en(load_en), .load_sec(load_sec),
      .load_ns(load_ns), .adj_en(adj_en), .adj_neg(adj_neg), .adj_mag(adj_mag),
      .sec(tod_sec), .ns(tod_ns), .sec_tick(sec_pulse)
   );
endmodule

// File: tb/tb_ptp_tod_counter.sv
`timescale 1ns/1ps
module tb_ptp_tod_counter;
   localparam int NPS     = 1000;
   localparam int ADJ_LIM = NPS - 256;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic [31:0] bus_wdata = 32'd0;
   logic [31:0] bus_rdata;
   logic [31:0] tod_sec;
   logic [29:0] tod_ns;
   logic        sec_pulse;

   always #4 clk = ~clk;

   ptp_tod_counter #(.NS_PER_SEC(NPS)) dut (
      .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tod_sec(tod_sec), .tod_ns(tod_ns),
      .sec_pulse(sec_pulse)
   );

   int    n_chk = 0, n_bad = 0;
   bit    done = 1'b0, lockstep = 1'b0;
   string cur_req = "R1";

   task automatic chk(string req, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // arithmetic model of the time, updated on each rising edge
   logic [31:0] m_sec, m_stage, m_shadow;
   longint      m_ns;
   int          m_cnt;
   logic [23:0] m_incr;
   bit          m_irq;

   always @(posedge clk) begin : model
      int          n, stp, ncnt;
      bit          alt;
      longint      t;
      logic [31:0] sec_old;
      if (rst) begin
         m_sec = 0; m_ns = 0; m_cnt = 0; m_incr = 0; m_stage = 0; m_shadow = 0; m_irq = 0;
      end else begin
         sec_old = m_sec;
         n    = int'(m_incr[23:16]);
         alt  = (n != 0) && (m_cnt == n);
         stp  = alt ? int'(m_incr[15:8]) : int'(m_incr[7:0]);
         ncnt = (n == 0 || alt) ? 0 : m_cnt + 1;
         m_irq = 0;
         if (bus_wr && bus_addr == 2'd0 && bus_wdata[29:0] < NPS) begin
            m_sec = m_stage;
            m_ns  = longint'(bus_wdata[29:0]);
         end else begin
            t = m_ns + stp;
            if (bus_wr && bus_addr == 2'd3 && bus_wdata[29:0] < ADJ_LIM)
               t = bus_wdata[31] ? t - longint'(bus_wdata[29:0]) : t + longint'(bus_wdata[29:0]);
            if (t >= NPS) begin t = t - NPS; m_sec = m_sec + 1; m_irq = 1; end
            else if (t < 0) begin t = t + NPS; m_sec = m_sec - 1; end
            m_ns = t;
         end
         if (bus_rd && bus_addr == 2'd0) m_shadow = sec_old;
         if (bus_wr && bus_addr == 2'd1) m_stage = bus_wdata;
         if (bus_wr && bus_addr == 2'd2) begin m_incr = bus_wdata[23:0]; ncnt = 0; end
         m_cnt = ncnt;
      end
   end

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (lockstep && !rst) begin
         chk({cur_req, " time.sec"}, longint'(tod_sec), longint'(m_sec));
         chk({cur_req, " time.ns"}, longint'(tod_ns), m_ns);
         chk({"R5 pulse/", cur_req}, longint'(sec_pulse), longint'(m_irq));
      end
   end

   function automatic longint total();
      return longint'(tod_sec) * NPS + longint'(tod_ns);
   endfunction

   task automatic wr(logic [1:0] a, logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = 32'd0;
   endtask

   task automatic rd(logic [1:0] a, output logic [31:0] d);
      bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic idle(int c);
      for (int i = 0; i < c; i++) @(negedge clk);
   endtask

   task automatic span(string req, int c, longint exp_delta);
      longint t0;
      t0 = total();
      idle(c);
      chk(req, total() - t0, exp_delta);
   endtask

   task automatic wr_delta(string req, logic [1:0] a, logic [31:0] d, longint exp_delta);
      longint t0;
      t0 = total();
      wr(a, d);
      chk(req, total() - t0, exp_delta);
   endtask

   initial begin : watchdog
      repeat (60000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] d, cap_sec;
      repeat (4) @(negedge clk);
      // R1: reset state
      chk("R1 sec in reset", longint'(tod_sec), 0);
      chk("R1 ns in reset", longint'(tod_ns), 0);
      chk("R1 pulse in reset", longint'(sec_pulse), 0);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 ns after release", longint'(tod_ns), 0);
      rd(2'd2, d);
      chk("R1 step word", longint'(d), 0);
      lockstep = 1'b1;

      // R2: default-only sweep, also many wraps (R4)
      cur_req = "R2";
      foreach (d[i]) begin end
      for (int k = 0; k < 5; k++) begin
         int st;
         st = (k == 0) ? 1 : (k == 1) ? 7 : (k == 2) ? 64 : (k == 3) ? 200 : 255;
         wr(2'd2, 32'(st));
         span("R2 default step", 150, longint'(st) * 150);
      end

      // R3: alternating pattern
      cur_req = "R3";
      wr(2'd2, 32'h00326462);
      span("R3 51-cycle period", 51, 5000);
      span("R3 three periods", 153, 15000);
      wr(2'd2, 32'h00F82814);
      span("R3 249-cycle period", 249, 5000);
      for (int n = 1; n <= 4; n++) begin
         wr(2'd2, {8'd0, 8'(n), 8'd10, 8'd3});
         span("R3 small run", 2 * (n + 1), 2 * (3 * n + 10));
      end

      // R8: restart and take-effect timing
      cur_req = "R8";
      wr(2'd2, {8'd0, 8'd2, 8'd10, 8'd3});
      idle(1);
      wr(2'd2, {8'd0, 8'd2, 8'd10, 8'd3});
      span("R8 restart at default", 2, 6);
      idle(1);
      wr_delta("R8 write cycle uses old word", 2'd2, 32'd50, 3);
      span("R8 new word next cycle", 1, 50);

      // R4/R5/R6: load near seconds rollover
      cur_req = "R6";
      wr(2'd2, 32'd7);
      wr(2'd1, 32'hFFFF_FFFF);
      wr(2'd0, 32'd990);
      chk("R6 load sec", longint'(tod_sec), longint'(32'hFFFF_FFFF));
      chk("R6 load ns", longint'(tod_ns), 990);
      chk("R5 no pulse on load", longint'(sec_pulse), 0);
      cur_req = "R4";
      @(negedge clk);
      chk("R4 ns before wrap", longint'(tod_ns), 997);
      @(negedge clk);
      chk("R4 carried ns", longint'(tod_ns), 4);
      chk("R4 sec rollover", longint'(tod_sec), 0);
      chk("R5 pulse on carry", longint'(sec_pulse), 1);
      @(negedge clk);
      chk("R5 pulse one cycle", longint'(sec_pulse), 0);
      cur_req = "R6";
      wr_delta("R6 bad ns ignored", 2'd0, 32'd1000, 7);
      wr(2'd1, 32'd5);
      wr(2'd0, 32'd2);
      chk("R6 load sec small", longint'(tod_sec), 5);

      // R7: corrections
      cur_req = "R7";
      wr(2'd3, 32'h8000_0000 | 32'd600);
      chk("R7 borrow sec", longint'(tod_sec), 4);
      chk("R7 borrow ns", longint'(tod_ns), 409);
      wr_delta("R7 add", 2'd3, 32'd700, 707);
      wr_delta("R7 subtract", 2'd3, 32'h8000_0000 | 32'd700, -693);
      wr_delta("R7 limit ignored", 2'd3, 32'(ADJ_LIM), 7);
      wr_delta("R7 below limit", 2'd3, 32'(ADJ_LIM - 1), longint'(ADJ_LIM + 6));

      // R9: coherent split read
      cur_req = "R9";
      wr(2'd2, 32'd250);
      bus_rd = 1'b1; bus_addr = 2'd0;
      #1 d = bus_rdata;
      chk("R9 ns read", longint'(d), longint'(tod_ns));
      cap_sec = tod_sec;
      @(negedge clk);
      bus_rd = 1'b0;
      idle(12);
      rd(2'd1, d);
      chk("R9 captured sec", longint'(d), longint'(cap_sec));
      chk("R9 live sec moved", longint'(tod_sec != cap_sec), 1);
      rd(2'd1, d);
      chk("R9 capture holds", longint'(d), longint'(cap_sec));

      // R10: readback
      cur_req = "R10";
      wr(2'd2, 32'hFF12_3456);
      rd(2'd2, d);
      chk("R10 step word readback", longint'(d), longint'(32'h0012_3456));
      rd(2'd3, d);
      chk("R10 correction reads zero", longint'(d), 0);
      idle(300);

      lockstep = 1'b0;
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule